// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block sits in the execute stage of a 64-bit pipeline whose instructions are 4 bytes long. For each control-transfer instruction it works out where fetch must go next and whether a return address is to be written. It handles three kinds of control transfer. The first is a PC-relative branch that depends on a condition. The second is a PC-relative branch that is always taken. The third is a jump whose target comes from a base register.

The block does not evaluate the register comparison itself; it receives the outcome as a single bit. A jump target keeps bit 0 of the sequential PC, which the pipeline uses as a privileged-mode marker. A return address is written only for the always-taken kinds, and never when the destination index names the hardwired zero register. All results pass through one register stage.

Top module: `bnu_next_pc`

## Requirements
- R1: When `ctl_valid_i` is low or `ctl_kind_i` is 2'b00, the registered next PC is PC + 4, and `taken_o` and `link_we_o` are both low.
- R2: The branch byte offset is the 21-bit `disp_i` field taken as signed and multiplied by 4. The branch target is PC + 4 + offset, with wraparound modulo 2^64.
- R3: A conditional branch (`ctl_kind_i` = 2'b01) goes to the branch target with `taken_o` high when `cond_i` is 1. When `cond_i` is 0 it goes to PC + 4 with `taken_o` low.
- R4: An unconditional branch (`ctl_kind_i` = 2'b10) always goes to the branch target with `taken_o` high, whatever the value of `cond_i`.
- R5: A jump (`ctl_kind_i` = 2'b11) always sets `taken_o`. Its target is `base_i` with bits [1:0] cleared, ORed with bit 0 of (PC + 4). Neither `disp_i` nor `cond_i` has any effect on a jump.
- R6: For an unconditional branch or a jump whose `link_idx_i` is not 31, `link_we_o` is high and `link_data_o` equals (PC + 4) with bits [1:0] cleared.
- R7: When `link_idx_i` is 31, `link_we_o` is low and `link_data_o` is zero for every kind.
- R8: A conditional branch never raises `link_we_o`, and `link_data_o` is then zero.
- R9: All outputs are registered, so inputs sampled at one rising edge appear after that edge. A synchronous `rst` drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid_i | input | 1 | A control instruction is present |
| ctl_kind_i | input | 2 | 00 none, 01 conditional branch, 10 unconditional branch, 11 jump |
| pc_i | input | 64 | Address of the current instruction |
| disp_i | input | 21 | Raw signed displacement field |
| base_i | input | 64 | Base register value for jumps |
| cond_i | input | 1 | Outcome of the branch condition |
| link_idx_i | input | 5 | Destination register index for the return address |
| npc_o | output | 64 | Registered next PC |
| taken_o | output | 1 | Registered control-transfer-taken flag |
| link_we_o | output | 1 | Registered return-address write enable |
| link_data_o | output | 64 | Registered return address, zero when not written |

## Verification
Conditional branches are driven with both condition values and with displacements at the most positive value, the most negative value and zero. This shows the sign extension and the shift by two, and it separates the taken path from the fall-through path. Jumps are driven with odd and even PCs, with base values that have their low bits set, and with nonzero displacements and conditions. A wrong source for bit 0, a missing mask of the low bits, or any use of the displacement therefore shows up in the target. The link index is swept across 31 and its neighbours on every kind, so a decode of the wrong kind or of the wrong zero index shows up as a stray or missing write. A PC at the top of the address space checks wraparound, and a reset in the middle of a run checks that the output register clears.

// File: rtl/bnu_pkg.sv
package bnu_pkg;

  typedef enum logic [1:0] {
    CK_NONE  = 2'b00,
    CK_BCOND = 2'b01,
    CK_BUNC  = 2'b10,
    CK_JUMP  = 2'b11
  } ctl_kind_e;

  typedef struct packed {
    logic is_ctl;
    logic is_bcond;
    logic is_bunc;
    logic is_jump;
  } kind_dec_t;

  function automatic kind_dec_t f_decode_kind(input logic valid, input ctl_kind_e kind);
    kind_dec_t d;
    d.is_bcond = valid && (kind == CK_BCOND);
    d.is_bunc  = valid && (kind == CK_BUNC);
    d.is_jump  = valid && (kind == CK_JUMP);
    d.is_ctl   = d.is_bcond || d.is_bunc || d.is_jump;
    return d;
  endfunction

endpackage

// File: rtl/bnu_seq_adder.sv
module bnu_seq_adder #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] seq_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  function automatic logic [XLEN-1:0] f_advance(input logic [XLEN-1:0] a);
    return a + STEP;
  endfunction

  assign seq_pc = f_advance(pc);
endmodule

// File: rtl/bnu_target_calc.sv
module bnu_target_calc #(
  parameter int XLEN       = 64,
  parameter int DISP_W     = 21,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   base,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   jmp_target
);
  localparam int SHIFT  = $clog2(INSN_BYTES);
  localparam int EXT_W  = XLEN - DISP_W - SHIFT;
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'(INSN_BYTES - 1);

  // Sign-extend and scale the displacement to a byte offset.
  function automatic logic [XLEN-1:0] f_branch_offset(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d, {SHIFT{1'b0}}};
  endfunction

  // Base with alignment bits cleared; bit 0 carries the mode flag from seq PC.
  function automatic logic [XLEN-1:0] f_jump_target(input logic [XLEN-1:0] b,
                                                    input logic [XLEN-1:0] s);
    logic [XLEN-1:0] t;
    t    = b & ~LOW_MASK;
    t[0] = t[0] | s[0];
    return t;
  endfunction

  assign br_target  = seq_pc + f_branch_offset(disp);
  assign jmp_target = f_jump_target(base, seq_pc);
endmodule

// File: rtl/bnu_link_ctl.sv
module bnu_link_ctl #(
  parameter int XLEN       = 64,
  parameter int REG_IDX_W  = 5,
  parameter int ZERO_REG   = 31,
  parameter int INSN_BYTES = 4
) (
  input  logic                 wants_link,
  input  logic [REG_IDX_W-1:0] link_idx,
  input  logic [XLEN-1:0]      seq_pc,
  output logic                 link_we,
  output logic [XLEN-1:0]      link_data
);
  localparam logic [REG_IDX_W-1:0] ZIDX     = REG_IDX_W'(ZERO_REG);
  localparam logic [XLEN-1:0]      LOW_MASK = XLEN'(INSN_BYTES - 1);

  function automatic logic [XLEN-1:0] f_ret_addr(input logic [XLEN-1:0] s);
    return s & ~LOW_MASK;
  endfunction

  assign link_we   = wants_link && (link_idx != ZIDX);
  assign link_data = link_we ? f_ret_addr(seq_pc) : '0;
endmodule

// File: rtl/bnu_select.sv
module bnu_select
  import bnu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  kind_dec_t       dec,
  input  logic            cond,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] jmp_target,
  output logic [XLEN-1:0] npc,
  output logic            taken,
  output logic            wants_link
);
  logic take_branch;

  assign take_branch = dec.is_bunc || (dec.is_bcond && cond);
  assign taken       = take_branch || dec.is_jump;
  assign wants_link  = dec.is_bunc || dec.is_jump;

  always_comb begin
    npc = seq_pc;
    if (dec.is_jump)      npc = jmp_target;
    else if (take_branch) npc = br_target;
  end
endmodule

// File: rtl/bnu_next_pc.sv
module bnu_next_pc
  import bnu_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int DISP_W     = 21,
  parameter int REG_IDX_W  = 5,
  parameter int ZERO_REG   = 31,
  parameter int INSN_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_valid_i,
  input  logic [1:0]           ctl_kind_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [XLEN-1:0]      base_i,
  input  logic                 cond_i,
  input  logic [REG_IDX_W-1:0] link_idx_i,
  output logic [XLEN-1:0]      npc_o,
  output logic                 taken_o,
  output logic                 link_we_o,
  output logic [XLEN-1:0]      link_data_o
);
  kind_dec_t       dec;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] npc_d;
  logic            taken_d;
  logic            wants_link;
  logic            link_we_d;
  logic [XLEN-1:0] link_data_d;

  assign dec = f_decode_kind(ctl_valid_i, ctl_kind_e'(ctl_kind_i));

  bnu_seq_adder #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_seq (
    .pc     (pc_i),
    .seq_pc (seq_pc)
  );

  bnu_target_calc #(.XLEN(XLEN), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .seq_pc     (seq_pc),
    .disp       (disp_i),
    .base       (base_i),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  bnu_select #(.XLEN(XLEN)) u_sel (
    .dec        (dec),
    .cond       (cond_i),
    .seq_pc     (seq_pc),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .npc        (npc_d),
    .taken      (taken_d),
    .wants_link (wants_link)
  );

  bnu_link_ctl #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .ZERO_REG(ZERO_REG),
                 .INSN_BYTES(INSN_BYTES)) u_link (
    .wants_link (wants_link),
    .link_idx   (link_idx_i),
    .seq_pc     (seq_pc),
    .link_we    (link_we_d),
    .link_data  (link_data_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o       <= '0;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      npc_o       <= npc_d;
      taken_o     <= taken_d;
      link_we_o   <= link_we_d;
      link_data_o <= link_data_d;
    end
  end
endmodule

// File: rtl/bnu_next_pc_chk.sv
module bnu_next_pc_chk #(
  parameter int XLEN       = 64,
  parameter int DISP_W     = 21,
  parameter int REG_IDX_W  = 5,
  parameter int ZERO_REG   = 31,
  parameter int INSN_BYTES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ctl_valid_i,
  input logic [1:0]           ctl_kind_i,
  input logic [XLEN-1:0]      pc_i,
  input logic [XLEN-1:0]      base_i,
  input logic [REG_IDX_W-1:0] link_idx_i,
  input logic                 wants_link,
  input logic [XLEN-1:0]      npc_o,
  input logic                 taken_o,
  input logic                 link_we_o,
  input logic [XLEN-1:0]      link_data_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] LOWM = XLEN'(INSN_BYTES - 1);

  p_seq_fallthrough_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !taken_o) |-> (npc_o == $past(pc_i) + STEP));

  p_no_ctl_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!ctl_valid_i)) |-> (!taken_o && !link_we_o));

  p_uncond_taken_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ctl_valid_i && ctl_kind_i[1]) |-> taken_o);

  p_jump_target_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ctl_valid_i && ctl_kind_i == 2'b11) |->
      ((npc_o[XLEN-1:1] == $past(base_i[XLEN-1:1] & ~LOWM[XLEN-1:1])) &&
       (npc_o[0] == $past(pc_i[0]))));

  p_link_data_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && link_we_o) |->
      (link_data_o == (($past(pc_i) + STEP) & ~LOWM)));

  p_link_needs_kind_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && link_we_o) |-> $past(wants_link));

  p_zero_idx_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(link_idx_i) == REG_IDX_W'(ZERO_REG)) |->
      (!link_we_o && link_data_o == '0));

  p_cond_nolink_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ctl_valid_i && ctl_kind_i == 2'b01) |-> !link_we_o);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (npc_o == '0 && !taken_o && !link_we_o && link_data_o == '0));
endmodule

bind bnu_next_pc bnu_next_pc_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .REG_IDX_W(REG_IDX_W),
  .ZERO_REG(ZERO_REG), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_valid_i (ctl_valid_i),
  .ctl_kind_i  (ctl_kind_i),
  .pc_i        (pc_i),
  .base_i      (base_i),
  .link_idx_i  (link_idx_i),
  .wants_link  (wants_link),
  .npc_o       (npc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/bnu_next_pc_bench.sv
module bnu_next_pc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_valid_i = 1'b0;
  logic [1:0]  ctl_kind_i = 2'b00;
  logic [63:0] pc_i = '0;
  logic [20:0] disp_i = '0;
  logic [63:0] base_i = '0;
  logic        cond_i = 1'b0;
  logic [4:0]  link_idx_i = '0;
  logic [63:0] npc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [63:0] link_data_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bnu_next_pc u_bnu_next_pc (
    .clk(clk), .rst(rst), .ctl_valid_i(ctl_valid_i), .ctl_kind_i(ctl_kind_i),
    .pc_i(pc_i), .disp_i(disp_i), .base_i(base_i), .cond_i(cond_i),
    .link_idx_i(link_idx_i), .npc_o(npc_o), .taken_o(taken_o),
    .link_we_o(link_we_o), .link_data_o(link_data_o)
  );

  // Reference expectations, filled from the requirements.
  logic [63:0] e_npc;
  logic        e_taken;
  logic        e_we;
  logic [63:0] e_data;

  task automatic model(input logic v, input logic [1:0] k, input logic [63:0] pc,
                       input logic [20:0] d, input logic [63:0] b, input logic c,
                       input logic [4:0] idx);
    longint      off;
    logic [63:0] nxt;
    nxt     = pc + 64'd4;
    off     = longint'($signed(d)) * 4;
    e_npc   = nxt;
    e_taken = 1'b0;
    e_we    = 1'b0;
    e_data  = '0;
    if (v) begin
      case (k)
        2'd1: if (c) begin e_taken = 1'b1; e_npc = nxt + 64'(off); end
        2'd2: begin e_taken = 1'b1; e_npc = nxt + 64'(off); e_we = (idx != 5'd31); end
        2'd3: begin
          e_taken = 1'b1;
          e_npc   = {b[63:2], 1'b0, nxt[0]};
          e_we    = (idx != 5'd31);
        end
        default: ;
      endcase
    end
    if (e_we) e_data = {nxt[63:2], 2'b00};
  endtask

  task automatic compare(input string tag);
    total++;
    if (npc_o !== e_npc || taken_o !== e_taken || link_we_o !== e_we ||
        link_data_o !== e_data) begin
      bad++;
      $display("FAIL %s: npc=%h taken=%0b we=%0b data=%h expected npc=%h taken=%0b we=%0b data=%h",
               tag, npc_o, taken_o, link_we_o, link_data_o, e_npc, e_taken, e_we, e_data);
    end
  endtask

  // Drive on the falling edge, let one rising edge register it, compare on the next falling edge.
  task automatic step(input logic v, input logic [1:0] k, input logic [63:0] pc,
                      input logic [20:0] d, input logic [63:0] b, input logic c,
                      input logic [4:0] idx, input string tag);
    ctl_valid_i = v; ctl_kind_i = k; pc_i = pc; disp_i = d;
    base_i = b; cond_i = c; link_idx_i = idx;
    model(v, k, pc, d, b, c, idx);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: expired expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    ctl_valid_i = 1'b1; ctl_kind_i = 2'd3; pc_i = 64'h1234; base_i = 64'hFFFF;
    link_idx_i = 5'd1;
    @(posedge clk); @(negedge clk);
    e_npc = '0; e_taken = 0; e_we = 0; e_data = '0;
    compare("R9 reset state");
    rst = 1'b0;

    // R1: no control instruction
    step(0, 2'd3, 64'h1000, 21'h1, 64'hABCD, 1, 5'd2, "R1 invalid");
    step(1, 2'd0, 64'h2000, 21'h7, 64'h5, 1, 5'd3, "R1 kind none");
    // R2/R3: conditional branch, offsets at the extremes
    step(1, 2'd1, 64'h4000_0000, 21'h0FFFFF, '0, 1, 5'd4, "R2 max positive disp");
    step(1, 2'd1, 64'h4000_0000, 21'h100000, '0, 1, 5'd4, "R2 most negative disp");
    step(1, 2'd1, 64'h4000_0000, 21'h000000, '0, 1, 5'd4, "R2 zero disp");
    step(1, 2'd1, 64'h4000_0000, 21'h000010, '0, 0, 5'd4, "R3 cond false");
    step(1, 2'd1, 64'h4000_0000, 21'h1FFFFF, '0, 1, 5'd4, "R3 cond true back");
    step(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFC, 21'h4, '0, 1, 5'd4, "R2 wraparound");
    // R4
    step(1, 2'd2, 64'h8000, 21'h20, '0, 0, 5'd26, "R4 uncond cond low");
    step(1, 2'd2, 64'h8000, 21'h1FFFF0, '0, 1, 5'd26, "R4 uncond cond high");
    // R5: jumps with odd/even PCs and dirty low base bits
    step(1, 2'd3, 64'h9001, 21'h1234, 64'hDEAD_BEEF_0000_0013, 0, 5'd26, "R5 odd pc");
    step(1, 2'd3, 64'h9000, 21'h0FFFFF, 64'hDEAD_BEEF_0000_0013, 1, 5'd26, "R5 even pc");
    step(1, 2'd3, 64'h9003, 21'h0, 64'h3, 0, 5'd0, "R5 base low only");
    // R6/R7/R8: link index sweep
    for (int i = 29; i < 32; i++) begin
      step(1, 2'd2, 64'hA002, 21'h3, '0, 0, 5'(i), "R6 R7 uncond link sweep");
      step(1, 2'd3, 64'hA001, 21'h3, 64'h77, 0, 5'(i), "R6 R7 jump link sweep");
      step(1, 2'd1, 64'hA000, 21'h3, '0, 1, 5'(i), "R8 cond no link");
    end
    step(1, 2'd3, 64'hB000, 21'h0, 64'h40, 0, 5'd31, "R7 jump zero reg");
    // R9: reset in the middle of a run
    ctl_valid_i = 1'b1; ctl_kind_i = 2'd2; pc_i = 64'hC000; link_idx_i = 5'd5;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    e_npc = '0; e_taken = 0; e_we = 0; e_data = '0;
    compare("R9 mid-run reset");
    rst = 1'b0;
    // Mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 7) != 0, 2'($urandom), {$urandom, $urandom},
           21'($urandom), {$urandom, $urandom}, 1'($urandom),
           ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom), "R1 R3 R4 R5 R6 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule